// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from a set of device slots onto four shared interrupt lines. Every slot owns four request pins. Each pin is steered to one shared line by a rotation that depends on the slot number, so the load spreads evenly across the lines. The block does not OR the pins together. Instead it stores the last level seen on every pin and keeps, for each line, a running count of the pins that are currently asserting it. A count changes only when some pin changes level. A line is driven high whenever its count is non-zero.

The counts also leave the block as a packed debug vector. A synchronous bus-clear input returns the block to a known state: it zeroes the counters, forgets every stored pin level, and passes through one settle cycle.

The controller has two states. `ST_CLEAR` holds the counters and stored levels at zero. `ST_TRACK` applies the summed changes in every cycle. The transitions are:

- Reset enters `ST_CLEAR`.
- `ST_CLEAR` moves to `ST_TRACK` on the next edge unless `bus_clear` is high.
- `ST_TRACK` returns to `ST_CLEAR` on any edge where `bus_clear` is high.

Top module: `irq_line_aggregator`

## Requirements
- R1: Pin p of slot s is bit `s*4+p` of `pin_lvl`. It feeds shared line `(p + s) mod 4`.
- R2: If no pin level differs from the stored level, no count changes, however often the same level is presented.
- R3: A rising pin adds one to its line count and a falling pin subtracts one. All changes seen at the same edge are summed and applied together. The new count is visible after that edge.
- R4: `irq_line[l]` is high exactly when the count of line l is non-zero.
- R5: An edge with `bus_clear` high zeroes all counts and stored levels and enters `ST_CLEAR`. The counts stay zero after the following settle edge. From the edge after that, each count equals the number of its pins that are held high.
- R6: After `rst_n` is released, the block starts in `ST_CLEAR`. All counts and lines are zero until the first `ST_TRACK` edge.
- R7: A count never wraps below zero and never exceeds NUM_SLOTS. With every pin high, each of the four counts equals NUM_SLOTS.
- R8: The count of line l appears at `line_count[l*CNT_W +: CNT_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clear | input | 1 | Synchronous bus clear |
| pin_lvl | input | 4*NUM_SLOTS | Request pin levels, slot-major |
| irq_line | output | 4 | Shared interrupt lines |
| line_count | output | 4*CNT_W | Per-line contributor counts |

## Verification
Every count is a running sum, so it never corrects itself. A missed or doubled change, a wrong route, or a stale stored level leaves a permanent offset. That offset shows on `line_count` in the cycle after the faulty edge and persists until the next clear. The bench therefore compares all four counts and lines after every edge against a population count of the high pins routed to each line. An error cannot hide behind later activity. The bench also probes the clear sequence edge by edge, because a missing settle cycle or unforgotten stored levels would show as non-zero counts, or as wrong counts on the first tracking edge.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int LINES = 4;
    localparam int PINS  = 4;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_TRACK = 1'b1
    } agg_state_e;

    // pin of a given slot that lands on a given line: (line - slot) mod 4
    function automatic int pin_for_line(input int line, input int slot);
        return (line - slot) & (PINS - 1);
    endfunction
endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
    parameter int N = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] pin_lvl,
    output logic [N-1:0] pin_q,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pin_q <= '0;
        else if (clr) pin_q <= '0;
        else          pin_q <= pin_lvl;
    end

    assign rise = pin_lvl & ~pin_q;
    assign fall = ~pin_lvl & pin_q;
endmodule

// File: rtl/irqagg_route.sv
module irqagg_route
    import irqagg_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int DW        = 9
) (
    input  logic [NUM_SLOTS*PINS-1:0] rise,
    input  logic [NUM_SLOTS*PINS-1:0] fall,
    output logic [LINES*DW-1:0]       delta_flat
);
    localparam logic signed [DW-1:0] ONE = 1;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic signed [DW-1:0] acc;
        always_comb begin
            acc = '0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (rise[s*PINS + pin_for_line(l, s)])
                    acc = acc + ONE;
                else if (fall[s*PINS + pin_for_line(l, s)])
                    acc = acc - ONE;
            end
        end
        assign delta_flat[l*DW +: DW] = acc;
    end
endmodule

// File: rtl/irqagg_counter.sv
module irqagg_counter #(
    parameter int CNT_W   = 8,
    parameter int DW      = 9,
    parameter int MAX_CNT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic signed [DW-1:0] delta,
    output logic [CNT_W-1:0]     count
);
    logic signed [DW-1:0] nxt;

    assign nxt = $signed({1'b0, count}) + delta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else          count <= nxt[CNT_W-1:0];
    end

    // R7: the summed change never drives the count out of range
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (nxt >= 0 && nxt <= MAX_CNT));

    // R3: a non-negative net change never lowers the count
    assert_rise_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && delta >= 0) |=> count >= $past(count));

    // R3: a non-positive net change never raises the count
    assert_fall_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && delta <= 0) |=> count <= $past(count));
endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator
    import irqagg_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int CNT_W     = $clog2(4 * NUM_SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_clear,
    input  logic [NUM_SLOTS*4-1:0]    pin_lvl,
    output logic [3:0]                irq_line,
    output logic [4*CNT_W-1:0]        line_count
);
    localparam int N  = NUM_SLOTS * PINS;
    localparam int DW = CNT_W + 1;

    agg_state_e state_q, state_d;
    logic       clr;
    logic [N-1:0] pin_q, rise, fall;
    logic [LINES*DW-1:0] delta_flat;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: state_d = bus_clear ? ST_CLEAR : ST_TRACK;
            ST_TRACK: state_d = bus_clear ? ST_CLEAR : ST_TRACK;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // control output: clear stored levels and counts
    always_comb begin
        unique case (state_q)
            ST_CLEAR: clr = 1'b1;
            ST_TRACK: clr = bus_clear;
            default:  clr = 1'b1;
        endcase
    end

    irqagg_edge #(.N(N)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .pin_lvl (pin_lvl),
        .pin_q   (pin_q),
        .rise    (rise),
        .fall    (fall)
    );

    irqagg_route #(.NUM_SLOTS(NUM_SLOTS), .DW(DW)) u_route (
        .rise       (rise),
        .fall       (fall),
        .delta_flat (delta_flat)
    );

    for (genvar l = 0; l < LINES; l++) begin : g_cnt
        irqagg_counter #(.CNT_W(CNT_W), .DW(DW), .MAX_CNT(NUM_SLOTS)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .delta (delta_flat[l*DW +: DW]),
            .count (line_count[l*CNT_W +: CNT_W])
        );
        assign irq_line[l] = |line_count[l*CNT_W +: CNT_W];
    end

    // R2: no level change means every count holds
    assert_repeat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && pin_lvl == pin_q) |=> $stable(line_count));

    // R5: a clear edge leaves all counts at zero
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (line_count == '0 && irq_line == 4'b0000));

    // R5: a clear request always enters the settle state
    assert_clear_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clear |=> state_q == ST_CLEAR);
endmodule

// File: tb/tb_irq_line_aggregator.sv
module tb_irq_line_aggregator;
    localparam int NS = 32;
    localparam int CW = 8;
    localparam int NP = NS * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_clear = 1'b0;
    logic [NP-1:0] pin_lvl = '0;
    logic [3:0]    irq_line;
    logic [4*CW-1:0] line_count;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_line_aggregator #(.NUM_SLOTS(NS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_clear  (bus_clear),
        .pin_lvl    (pin_lvl),
        .irq_line   (irq_line),
        .line_count (line_count)
    );

    // R1 model: pin p of slot s goes to line (p+s) mod 4
    function automatic int exp_cnt(input logic [NP-1:0] v, input int line);
        int c = 0;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 4; p++)
                if (v[s*4+p] && ((p + s) % 4) == line) c++;
        return c;
    endfunction

    task automatic check_lines(input string req, input bit zero);
        for (int l = 0; l < 4; l++) begin
            int e = zero ? 0 : exp_cnt(pin_lvl, l);
            int a = int'(line_count[l*CW +: CW]);
            checks++;
            if (a != e) begin
                errors++;
                $display("FAIL %s line %0d count actual %0d expected %0d", req, l, a, e);
            end
            checks++;
            if (irq_line[l] != (e != 0)) begin
                errors++;
                $display("FAIL R4 line %0d irq actual %0d expected %0d", l, irq_line[l], e != 0);
            end
        end
    endtask

    task automatic step;
        @(posedge clk);
        #5;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) step();
        check_lines("R6", 1'b1);          // in reset
        rst_n = 1'b1;
        pin_lvl = '1;
        step();
        check_lines("R6", 1'b1);          // first edge is the settle edge
        step();
        check_lines("R7", 1'b0);          // all high: NS per line
        step();
        check_lines("R2", 1'b0);          // same level again
        step();
        check_lines("R2", 1'b0);
        pin_lvl = '0;
        step();
        check_lines("R3", 1'b0);          // all fall at once
        pin_lvl[5*4+2] = 1'b1;            // slot 5 pin 2 -> line 3
        step();
        check_lines("R1", 1'b0);
        checks++;
        if (line_count[3*CW +: CW] != 8'd1) begin
            errors++;
            $display("FAIL R8 line3 field actual %0d expected 1", line_count[3*CW +: CW]);
        end
        pin_lvl[5*4+2] = 1'b0;            // fall on line 3 ...
        pin_lvl[6*4+1] = 1'b1;            // ... and rise on line 3, same edge
        pin_lvl[31*4+3] = 1'b1;           // slot 31 pin 3 -> line 2
        step();
        check_lines("R3", 1'b0);
        checks++;
        if (line_count != {8'd1, 8'd1, 8'd0, 8'd0}) begin
            errors++;
            $display("FAIL R1 packed counts actual %h expected %h", line_count, {8'd1, 8'd1, 8'd0, 8'd0});
        end
        // random flips
        for (int i = 0; i < 400; i++) begin
            int nflip = $urandom_range(0, 6);
            for (int k = 0; k < nflip; k++)
                pin_lvl[$urandom_range(0, NP-1)] ^= 1'b1;
            if (($urandom % 50) == 0) begin
                bus_clear = 1'b1;
                step();
                check_lines("R5", 1'b1);
                bus_clear = 1'b0;
                step();
                check_lines("R5", 1'b1);
                step();
                check_lines("R5", 1'b0);
            end else begin
                step();
                check_lines("R3", 1'b0);
            end
        end
        // directed clear with all pins high
        pin_lvl = '1;
        bus_clear = 1'b1;
        step();
        check_lines("R5", 1'b1);
        bus_clear = 1'b0;
        step();
        check_lines("R5", 1'b1);
        step();
        check_lines("R7", 1'b0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule